// File: doc/BRIEF.md
# Weighted Spike Train Compressor

This block shortens one binary spike channel in time. It gathers a programmable number of consecutive binary spike samples, the ratio, which may be any integer from 1 to 16. For each group it emits a single multi-bit weighted spike, and the weight is the number of ones in the group. Because the block counts the ones rather than OR-merging them, the total spike count of the channel is kept exactly at every ratio. Only the fine timing inside each group is lost.

The channel can arrive in two ways. As a serial bit stream, the samples come in on their own strobe, and a demultiplexer writes each one into the next slot of a window register. The sample clock therefore runs the ratio times faster than the output step rate. As a parallel word, all samples of one step come in at once, and the gathering stage is bypassed.

When a window closes, the block sums its bits and registers the sum as a weight, together with a one-cycle step strobe. When the ratio or the input mode changes, the window under construction is dropped and the block starts clean under the new setting.

Top module: `spike_time_compressor`

## Requirements
- R1: In serial mode, every window of `ratio` accepted samples produces one weight. The weight equals the number of ones among those samples. This holds for every ratio from 1 to 16, powers of two or not.
- R2: `stepValid` is high for exactly one cycle. That cycle immediately follows the clock edge that accepts the last sample of a window, so the first output comes after exactly `ratio` samples. No output appears for a window that is not yet full.
- R3: A serial sample is accepted only on a cycle with `serValid` high. Cycles with `serValid` low are not counted and do not change the window.
- R4: With `parallelMode` = 1, each cycle with `parValid` high produces a weight one cycle later. That weight equals the number of ones in `parWord[ratio-1:0]`, with bit 0 as the first lane. Bits at positions `ratio` and above are ignored, and the serial inputs are ignored in this mode.
- R5: `weightOut` reads 0 on every cycle where `stepValid` is low. A step whose weight is 0 is still strobed and means that the step carried no spike.
- R6: A `ratioCfg` value of 0 acts as ratio 1. Any value above 16 acts as ratio 16.
- R7: A cycle in which the clamped ratio or `parallelMode` differs from the setting in use is a reconfiguration cycle. In that cycle the partial window is discarded and any sample offered is dropped. The next window starts with the first sample after it.
- R8: While `rstN` is low at a clock edge, `stepValid` and `weightOut` become 0 and the window is emptied. The setting present on the inputs is adopted without a reconfiguration cycle.
- R9: Over any run, the sum of all output weights equals the number of ones in all accepted samples of completed windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the serial sample rate |
| rstN | input | 1 | Synchronous active-low reset |
| ratioCfg | input | 5 | Requested compression ratio, clamped to 1..16 |
| parallelMode | input | 1 | 0: serial input, 1: parallel word input |
| serBit | input | 1 | Serial spike sample |
| serValid | input | 1 | Serial sample present this cycle |
| parWord | input | 16 | Parallel spike word, lane 0 first |
| parValid | input | 1 | Parallel word present this cycle |
| weightOut | output | 5 | Weight of the compressed spike, 0..16 |
| stepValid | output | 1 | One-cycle strobe per compressed step |

## Verification
The bench builds the block with its default parameters: a 16-lane window and a 5-bit ratio field. With these values it can sweep every ratio from 1 through 16, including the odd and non-power-of-two ones. The 5-bit field also reaches the out-of-range codes 17 to 31, which exercises the clamp, and a full 16-lane parallel word can carry a weight of 16. The bench also changes the setting in mid-window, offers a sample in the change cycle, applies a reset in mid-window and leaves idle gaps between serial samples.

// File: rtl/spkcmp_pkg.sv
package spkcmp_pkg;

  typedef enum logic {
    SRC_SERIAL   = 1'b0,
    SRC_PARALLEL = 1'b1
  } srcMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // write serial sample into current slot
    logic closeWin;  // window complete, publish weight
    logic clearWin;  // reconfiguration, drop partial window
    logic usePar;    // parallel word is the window source
  } winStrobes_t;

endpackage

// File: rtl/spkcmp_ctrl.sv
module spkcmp_ctrl
  import spkcmp_pkg::*;
#(
  parameter int MAX_RATIO = 16,
  parameter int RATIO_W   = 5,
  parameter int IDX_W     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioCfg,
  input  logic               parallelMode,
  input  logic               serValid,
  input  logic               parValid,
  output winStrobes_t        strobes,
  output logic [IDX_W-1:0]   wrIdx,
  output logic [RATIO_W-1:0] activeRatio
);

  logic [RATIO_W-1:0] reqRatio;
  srcMode_e           reqMode;
  srcMode_e           activeMode;
  logic               cfgChange;
  logic               lastSlot;

  // clamp the requested ratio into 1..MAX_RATIO
  always_comb begin
    if (ratioCfg == '0)
      reqRatio = RATIO_W'(1);
    else if (ratioCfg > RATIO_W'(MAX_RATIO))
      reqRatio = RATIO_W'(MAX_RATIO);
    else
      reqRatio = ratioCfg;
  end

  assign reqMode   = parallelMode ? SRC_PARALLEL : SRC_SERIAL;
  assign cfgChange = (reqRatio != activeRatio) || (reqMode != activeMode);
  assign lastSlot  = (RATIO_W'(wrIdx) == (activeRatio - RATIO_W'(1)));

  always_comb begin
    strobes.usePar   = (activeMode == SRC_PARALLEL);
    strobes.clearWin = cfgChange;
    strobes.shiftIn  = !cfgChange && (activeMode == SRC_SERIAL) && serValid;
    strobes.closeWin = (strobes.shiftIn && lastSlot) ||
                       (!cfgChange && (activeMode == SRC_PARALLEL) && parValid);
  end

  always_ff @(posedge clk) begin
    if (!rstN || cfgChange) begin
      activeRatio <= reqRatio;
      activeMode  <= reqMode;
      wrIdx       <= '0;
    end else if (strobes.shiftIn) begin
      wrIdx <= lastSlot ? '0 : wrIdx + IDX_W'(1);
    end
  end

  // R6
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeRatio >= RATIO_W'(1)) && (activeRatio <= RATIO_W'(MAX_RATIO)));

  // R1
  slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    RATIO_W'(wrIdx) < activeRatio);

  // R7
  reconfig_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearWin |=> (wrIdx == '0) && (activeRatio == $past(reqRatio)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.shiftIn && !strobes.clearWin) |=> $stable(wrIdx));

  // R2
  single_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.closeWin && strobes.clearWin));

endmodule

// File: rtl/spkcmp_datapath.sv
module spkcmp_datapath
  import spkcmp_pkg::*;
#(
  parameter int MAX_RATIO = 16,
  parameter int RATIO_W   = 5,
  parameter int IDX_W     = 4,
  parameter int WEIGHT_W  = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  winStrobes_t          strobes,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [RATIO_W-1:0]   activeRatio,
  input  logic                 serBit,
  input  logic [MAX_RATIO-1:0] parWord,
  output logic [WEIGHT_W-1:0]  weightOut,
  output logic                 stepValid
);

  logic [MAX_RATIO-1:0] winBits;
  logic [MAX_RATIO-1:0] laneMask;
  logic [MAX_RATIO-1:0] serialFull;
  logic [MAX_RATIO-1:0] selBits;
  logic [WEIGHT_W-1:0]  weightSum;

  // lanes at or above the active ratio are masked off
  for (genvar g = 0; g < MAX_RATIO; g++) begin : g_lane
    assign laneMask[g] = (RATIO_W'(g) < activeRatio);
  end

  // serial window including the sample arriving now
  always_comb begin
    serialFull = winBits;
    serialFull[wrIdx] = serBit;
  end

  assign selBits = strobes.usePar ? (parWord & laneMask) : serialFull;

  // ones counter across all lanes
  always_comb begin
    weightSum = '0;
    for (int i = 0; i < MAX_RATIO; i++)
      weightSum = weightSum + WEIGHT_W'(selBits[i]);
  end

  // demultiplexed window register
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearWin || strobes.closeWin)
      winBits <= '0;
    else if (strobes.shiftIn)
      winBits[wrIdx] <= serBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepValid <= 1'b0;
      weightOut <= '0;
    end else begin
      stepValid <= strobes.closeWin;
      weightOut <= strobes.closeWin ? weightSum : '0;
    end
  end

  // R1
  weight_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |-> (RATIO_W'(weightOut) <= $past(activeRatio)));

  // R5
  quiet_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stepValid |-> (weightOut == '0));

  // R7
  window_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearWin |=> (winBits == '0));

endmodule

// File: rtl/spike_time_compressor.sv
module spike_time_compressor
  import spkcmp_pkg::*;
#(
  parameter int MAX_RATIO = 16,
  localparam int RATIO_W  = $clog2(MAX_RATIO + 1),
  localparam int WEIGHT_W = $clog2(MAX_RATIO + 1),
  localparam int IDX_W    = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [RATIO_W-1:0]   ratioCfg,
  input  logic                 parallelMode,
  input  logic                 serBit,
  input  logic                 serValid,
  input  logic [MAX_RATIO-1:0] parWord,
  input  logic                 parValid,
  output logic [WEIGHT_W-1:0]  weightOut,
  output logic                 stepValid
);

  winStrobes_t        strobes;
  logic [IDX_W-1:0]   wrIdx;
  logic [RATIO_W-1:0] activeRatio;

  spkcmp_ctrl #(
    .MAX_RATIO (MAX_RATIO),
    .RATIO_W   (RATIO_W),
    .IDX_W     (IDX_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .ratioCfg     (ratioCfg),
    .parallelMode (parallelMode),
    .serValid     (serValid),
    .parValid     (parValid),
    .strobes      (strobes),
    .wrIdx        (wrIdx),
    .activeRatio  (activeRatio)
  );

  spkcmp_datapath #(
    .MAX_RATIO (MAX_RATIO),
    .RATIO_W   (RATIO_W),
    .IDX_W     (IDX_W),
    .WEIGHT_W  (WEIGHT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrIdx       (wrIdx),
    .activeRatio (activeRatio),
    .serBit      (serBit),
    .parWord     (parWord),
    .weightOut   (weightOut),
    .stepValid   (stepValid)
  );

endmodule

// File: tb/spike_time_compressor_tb.sv
module spike_time_compressor_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  ratioCfg;
  logic        parallelMode;
  logic        serBit;
  logic        serValid;
  logic [15:0] parWord;
  logic        parValid;
  logic [4:0]  weightOut;
  logic        stepValid;

  int total = 0;
  int bad = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  int expQ[$];
  string tagQ[$];

  int mRatio, mCount, mOnes;
  int sumIn = 0;
  int sumOut = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  spike_time_compressor u_dut (
    .clk(clk), .rstN(rstN), .ratioCfg(ratioCfg), .parallelMode(parallelMode),
    .serBit(serBit), .serValid(serValid), .parWord(parWord), .parValid(parValid),
    .weightOut(weightOut), .stepValid(stepValid)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampRatio(int r);
    if (r == 0) return 1;
    if (r > 16) return 16;
    return r;
  endfunction

  function automatic int maskedOnes(logic [15:0] w, int r);
    int n = 0;
    for (int i = 0; i < r; i++) n += w[i];
    return n;
  endfunction

  // monitor: compare every strobed weight against the scoreboard
  always @(negedge clk) begin
    if (running) begin
      if (stepValid) begin
        if (expQ.size() == 0) begin
          chk("R2 unexpected step", 1, 0);
        end else begin
          chk(tagQ.pop_front(), int'(weightOut), expQ.pop_front());
          sumOut += int'(weightOut);
        end
      end else if (weightOut != 5'd0) begin
        chk("R5 weight while idle", int'(weightOut), 0);
      end
    end
  end

  task automatic modelClear();
    mCount = 0;
    mOnes = 0;
  endtask

  // reconfiguration cycle, optionally with a sample that must be dropped (R7)
  task automatic applyCfg(int r, bit par, bit withSample = 1'b0);
    ratioCfg = 5'(r);
    parallelMode = par;
    serValid = withSample;
    serBit = 1'b1;
    parValid = 1'b0;
    mRatio = clampRatio(r);
    modelClear();
    @(negedge clk);
    serValid = 1'b0;
  endtask

  task automatic serSample(bit b, string tag);
    serBit = b;
    serValid = 1'b1;
    mOnes += b;
    mCount++;
    if (mCount == mRatio) begin
      expQ.push_back(mOnes);
      tagQ.push_back(tag);
      sumIn += mOnes;
      modelClear();
    end
    @(negedge clk);
    serValid = 1'b0;
  endtask

  task automatic parSample(logic [15:0] w, string tag);
    parWord = w;
    parValid = 1'b1;
    serValid = 1'b1;
    serBit = 1'b1;
    expQ.push_back(maskedOnes(w, mRatio));
    tagQ.push_back(tag);
    sumIn += maskedOnes(w, mRatio);
    @(negedge clk);
    parValid = 1'b0;
    serValid = 1'b0;
  endtask

  task automatic idle(int n);
    serValid = 1'b0;
    parValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic bit nextBit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    ratioCfg = 5'd4;
    parallelMode = 1'b0;
    serBit = 1'b0;
    serValid = 1'b0;
    parWord = '0;
    parValid = 1'b0;
    mRatio = 4;
    modelClear();
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 stepValid in reset", int'(stepValid), 0);
    chk("R8 weight in reset", int'(weightOut), 0);
    rstN = 1'b1;
    running = 1'b1;
    idle(2);

    // R1 ratio 4 pattern 1,1,0,0 gives weight 2
    serSample(1, "R1 ratio4 1100");
    serSample(1, "R1 ratio4 1100");
    serSample(0, "R1 ratio4 1100");
    // R2 no output before the window is full
    chk("R2 early strobe", int'(stepValid), 0);
    serSample(0, "R1 ratio4 1100");
    chk("R2 strobe after 4th sample", int'(stepValid), 1);
    chk("R1 weight of 1100", int'(weightOut), 2);
    @(negedge clk);
    chk("R2 strobe one cycle", int'(stepValid), 0);

    // R3 gaps between serial samples are not counted
    applyCfg(5, 1'b0);
    for (int i = 0; i < 5; i++) begin
      serSample(1'(i % 2 == 0), "R3 gapped window");
      idle(i + 1);
    end
    idle(2);

    // R1 sweep of every ratio, two windows each
    for (int r = 1; r <= 16; r++) begin
      applyCfg(r, 1'b0);
      for (int k = 0; k < 2 * r; k++) serSample(nextBit(), "R1 sweep");
      idle(1);
    end
    applyCfg(16, 1'b0);
    for (int k = 0; k < 16; k++) serSample(1'b1, "R1 full window 16");
    idle(2);

    // R6 clamp of 0 and of out-of-range codes
    applyCfg(0, 1'b0);
    serSample(1, "R6 ratio0 as 1");
    serSample(0, "R6 ratio0 as 1");
    applyCfg(20, 1'b0);
    for (int k = 0; k < 16; k++) serSample(1'(k % 3 == 0), "R6 ratio20 as 16");
    idle(2);
    applyCfg(31, 1'b0);
    for (int k = 0; k < 16; k++) serSample(1'b1, "R6 ratio31 as 16");
    idle(2);

    // R4 parallel mode with masked high lanes, serial inputs toggling
    applyCfg(5, 1'b1);
    parSample(16'hFFFF, "R4 ratio5 all ones");
    parSample(16'hFFE0, "R4 ratio5 high lanes only");
    applyCfg(16, 1'b1);
    parSample(16'hA5A5, "R4 ratio16 pattern");
    parSample(16'hFFFF, "R4 ratio16 weight 16");
    applyCfg(1, 1'b1);
    parSample(16'h0002, "R5 zero weight strobed");
    idle(1);
    parSample(16'h0001, "R4 ratio1 lane0");
    idle(2);

    // R7 ratio change mid-window discards partial work
    applyCfg(8, 1'b0);
    for (int k = 0; k < 3; k++) serSample(1'b1, "R7 discarded");
    applyCfg(4, 1'b0, 1'b1);
    serSample(0, "R7 new window");
    serSample(1, "R7 new window");
    serSample(0, "R7 new window");
    serSample(0, "R7 new window");
    idle(2);
    // R7 mode change mid-window
    applyCfg(6, 1'b0);
    for (int k = 0; k < 4; k++) serSample(1'b1, "R7 discarded");
    applyCfg(6, 1'b1);
    parSample(16'h0003, "R7 after mode switch");
    applyCfg(6, 1'b0);
    for (int k = 0; k < 6; k++) serSample(1'(k == 5), "R7 back to serial");
    idle(2);

    // R8 reset in mid-window empties the window
    applyCfg(4, 1'b0);
    serSample(1, "R8 pre-reset");
    serSample(1, "R8 pre-reset");
    rstN = 1'b0;
    modelClear();
    @(negedge clk);
    chk("R8 outputs under reset", int'(stepValid) + int'(weightOut), 0);
    rstN = 1'b1;
    serSample(1, "R8 after reset");
    serSample(0, "R8 after reset");
    serSample(1, "R8 after reset");
    serSample(0, "R8 after reset");
    idle(3);

    // R2 every expected step was produced; R9 spike count conserved
    chk("R2 missing steps", expQ.size(), 0);
    chk("R9 weight sum", sumOut, sumIn);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule